// File: doc/BRIEF.md
# Bidirectional Timer with Buffered Compare

An 8-bit timer whose count moves by one on each enabled tick. It can count up and wrap, count up to a compare value and restart, or count up to the maximum and back down to zero. The count is compared against an active compare value on every tick. A match sets a sticky compare flag, and a rollover or bottom event sets a sticky overflow flag. Each flag drives an interrupt request through its own enable bit.

Software reaches the block through a 2-bit register address with a write strobe and a combinational read port. The address map is: 0 is the count, 1 is the compare buffer, 2 is control, and 3 is the flags. The compare value is written into a buffer. In the two up-counting modes the buffer is copied into the active value at once. In the up/down mode the copy waits for the turnaround at the top. A control bit selects the tick: either every clock cycle, or only the cycles in which an external enable input is high.

Top module: `updn_timer`

## Requirements
- R1: While reset is high and on the first cycle after it, the count, the compare buffer, the control register and both flags read as zero, both interrupt outputs are low, and the direction is up.
- R2: Control bit 2 picks the tick. When it is 0 the counter advances on every clock cycle. When it is 1 the counter advances only in cycles where `ext_tick` is high, and otherwise holds its value.
- R3: In mode 0 (control bits 1:0 = 0, and code 3 behaves the same) the count increments on each tick. The tick at 0xFF gives 0x00 and sets the overflow flag (flags bit 1).
- R4: In mode 1 a tick where the count equals the active compare value gives 0x00. A tick at 0xFF with no equality gives 0x00 and sets the overflow flag.
- R5: In mode 2 the count rises to 0xFF and the next tick gives 0xFE with the direction turned down. It then falls, and the tick that lands on 0x00 sets the overflow flag. The tick after that gives 0x01 with the direction up again.
- R6: A tick where the count equals the active compare value sets the compare flag (flags bit 0).
- R7: Writes to address 1 go to the compare buffer, which reads back at address 1. In modes 0 and 1 the active compare value takes the new value on the same edge. In mode 2 the active value is loaded from the buffer only on the tick at 0xFF while counting up.
- R8: A write to address 0 replaces the count. It wins over a tick in the same cycle, and the first tick after it sets no compare flag.
- R9: Flags stay set until software writes a 1 to their bit at address 3. Writing 0 leaves a flag unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R10: `irq_cmp` equals the compare flag ANDed with control bit 3, and `irq_ovf` equals the overflow flag ANDed with control bit 4.
- R11: The read port returns the count at address 0, the compare buffer at 1, control bits 4:0 at 2 with upper bits zero, and the flags in bits 1:0 at 3 with upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_tick | input | 1 | External count enable, used when control bit 2 is 1 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Combinational read data |
| irq_cmp | output | 1 | Compare-match interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
The in-line assertions check the following on every cycle:
- the count moves by at most one step per tick and holds without one;
- a count write lands exactly;
- the turnaround at 0xFF in up/down mode goes to 0xFE;
- the active compare value stays frozen between top events in up/down mode;
- a match raises the flag;
- an interrupt line never rises without its flag.

Some behaviour only the bench scenarios can show:
- that the deferred compare update actually takes effect at the next top;
- the suppressed match after a count write;
- the overflow placement at bottom;
- the clear semantics of the flag register;
- the read map.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W  = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [1:0] {
        M_WRAP = 2'd0,
        M_CTC  = 2'd1,
        M_UPDN = 2'd2,
        M_RSVD = 2'd3
    } mode_t;

    typedef struct packed {
        logic  ovf_ie;
        logic  cmp_ie;
        logic  src_ext;
        mode_t mode;
    } ctrl_t;

    typedef struct packed {
        logic ovf;
        logic cmp;
    } flags_t;

    localparam logic [ADDR_W-1:0] A_CNT = 2'd0;
    localparam logic [ADDR_W-1:0] A_CMP = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTL = 2'd2;
    localparam logic [ADDR_W-1:0] A_FLG = 2'd3;

    localparam int CTL_W = $bits(ctrl_t);
    localparam int FLG_W = $bits(flags_t);

    function automatic logic is_max(input logic [CNT_W-1:0] v);
        return &v;
    endfunction

    function automatic logic is_bottom(input logic [CNT_W-1:0] v);
        return ~|v;
    endfunction

endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel (
    input  logic src_ext,
    input  logic ext_tick,
    output logic tick
);
    always_comb begin
        if (src_ext) tick = ext_tick;
        else         tick = 1'b1;
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  mode_t        mode,
    input  logic [W-1:0] top_val,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output logic         dir_dn,
    output logic         ovf_evt,
    output logic         top_up_evt
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_nxt;
    logic         dir_nxt;

    always_comb begin
        cnt_nxt    = cnt;
        dir_nxt    = dir_dn;
        ovf_evt    = 1'b0;
        top_up_evt = 1'b0;
        if (ld) begin
            cnt_nxt = ld_val;
        end else if (tick) begin
            case (mode)
                M_UPDN: begin
                    if (!dir_dn) begin
                        if (cnt == MAXV) begin
                            cnt_nxt    = MAXV - ONE;
                            dir_nxt    = 1'b1;
                            top_up_evt = 1'b1;
                        end else begin
                            cnt_nxt = cnt + ONE;
                        end
                    end else begin
                        if (cnt == '0) begin
                            cnt_nxt = ONE;
                            dir_nxt = 1'b0;
                        end else begin
                            cnt_nxt = cnt - ONE;
                            ovf_evt = (cnt == ONE);
                        end
                    end
                end
                M_CTC: begin
                    if (cnt == top_val) begin
                        cnt_nxt = '0;
                    end else if (cnt == MAXV) begin
                        cnt_nxt = '0;
                        ovf_evt = 1'b1;
                    end else begin
                        cnt_nxt = cnt + ONE;
                    end
                end
                default: begin
                    cnt_nxt = cnt + ONE;
                    ovf_evt = (cnt == MAXV);
                end
            endcase
        end
        if (mode != M_UPDN) dir_nxt = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            dir_dn <= 1'b0;
        end else begin
            cnt    <= cnt_nxt;
            dir_dn <= dir_nxt;
        end
    end

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ld) |=> $stable(cnt)) else $error("hold without tick"); // R2

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && !ld) |=> (cnt == W'($past(cnt) + ONE) || cnt == W'($past(cnt) - ONE) || cnt == '0))
        else $error("step larger than one"); // R3

    AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (rst)
        ld |=> (cnt == $past(ld_val))) else $error("count load lost"); // R8

    AST_TURN_TOP: assert property (@(posedge clk) disable iff (rst)
        (tick && !ld && mode == M_UPDN && !dir_dn && is_max(cnt)) |=> (cnt == MAXV - ONE && dir_dn))
        else $error("turnaround at top"); // R5

endmodule

// File: rtl/tmr_compare.sv
module tmr_compare
    import tmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  mode_t        mode,
    input  logic         wr,
    input  logic [W-1:0] wr_val,
    input  logic         upd,
    input  logic         tick,
    input  logic         ld,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] buf_val,
    output logic [W-1:0] act_val,
    output logic         hit
);
    logic [W-1:0] buf_nxt;
    logic         blk_q;

    assign buf_nxt = wr ? wr_val : buf_val;
    assign hit     = tick && !ld && !blk_q && (cnt == act_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_val <= '0;
            act_val <= '0;
            blk_q   <= 1'b0;
        end else begin
            buf_val <= buf_nxt;
            if (mode != M_UPDN) act_val <= buf_nxt;
            else if (upd)       act_val <= buf_val;
            if (ld)        blk_q <= 1'b1;
            else if (tick) blk_q <= 1'b0;
        end
    end

    AST_ACT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (mode == M_UPDN && !upd) |=> $stable(act_val)) else $error("active compare moved"); // R7

    AST_NO_HIT_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        ld |=> !hit) else $error("match after load"); // R8

endmodule

// File: rtl/updn_timer.sv
module updn_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq_cmp,
    output logic              irq_ovf
);
    ctrl_t              ctrl_q;
    flags_t             flg_q;
    logic               tick;
    logic               ld_cnt;
    logic               wr_cmp;
    logic               clr_w;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   buf_val;
    logic [CNT_W-1:0]   act_val;
    logic               dir_dn;
    logic               ovf_evt;
    logic               top_up_evt;
    logic               hit;

    assign ld_cnt = wr_en && (wr_addr == A_CNT);
    assign wr_cmp = wr_en && (wr_addr == A_CMP);
    assign clr_w  = wr_en && (wr_addr == A_FLG);

    tmr_tick_sel u_tick (
        .src_ext  (ctrl_q.src_ext),
        .ext_tick (ext_tick),
        .tick     (tick)
    );

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .mode       (ctrl_q.mode),
        .top_val    (act_val),
        .ld         (ld_cnt),
        .ld_val     (wr_data),
        .cnt        (cnt),
        .dir_dn     (dir_dn),
        .ovf_evt    (ovf_evt),
        .top_up_evt (top_up_evt)
    );

    tmr_compare #(.W(CNT_W)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .mode    (ctrl_q.mode),
        .wr      (wr_cmp),
        .wr_val  (wr_data),
        .upd     (top_up_evt),
        .tick    (tick),
        .ld      (ld_cnt),
        .cnt     (cnt),
        .buf_val (buf_val),
        .act_val (act_val),
        .hit     (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            flg_q  <= '0;
        end else begin
            if (wr_en && wr_addr == A_CTL) ctrl_q <= ctrl_t'(wr_data[CTL_W-1:0]);
            if (hit)                         flg_q.cmp <= 1'b1;
            else if (clr_w && wr_data[0])    flg_q.cmp <= 1'b0;
            if (ovf_evt)                     flg_q.ovf <= 1'b1;
            else if (clr_w && wr_data[1])    flg_q.ovf <= 1'b0;
        end
    end

    assign irq_cmp = flg_q.cmp & ctrl_q.cmp_ie;
    assign irq_ovf = flg_q.ovf & ctrl_q.ovf_ie;

    always_comb begin
        case (rd_addr)
            A_CNT:   rd_data = cnt;
            A_CMP:   rd_data = buf_val;
            A_CTL:   rd_data = {{(CNT_W-CTL_W){1'b0}}, ctrl_q};
            default: rd_data = {{(CNT_W-FLG_W){1'b0}}, flg_q};
        endcase
    end

    AST_CMP_STICKY: assert property (@(posedge clk) disable iff (rst)
        hit |=> flg_q.cmp) else $error("compare flag not set"); // R6

    AST_OVF_SETS: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> flg_q.ovf) else $error("overflow flag not set"); // R9

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (flg_q.cmp && !(clr_w && wr_data[0])) |=> flg_q.cmp) else $error("flag dropped"); // R9

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (irq_cmp || irq_ovf) |-> (flg_q.cmp || flg_q.ovf)) else $error("irq without flag"); // R10

    AST_DIR_UP_OUTSIDE_UPDN: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.mode != M_UPDN) |=> (!dir_dn || ctrl_q.mode == M_UPDN)) else $error("direction stuck down"); // R5

endmodule

// File: tb/updn_timer_tb_top.sv
`timescale 1ns/100ps
module updn_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq_cmp;
    logic       irq_ovf;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    updn_timer dut_i (
        .clk      (clk),
        .rst      (rst),
        .ext_tick (ext_tick),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .irq_cmp  (irq_cmp),
        .irq_ovf  (irq_ovf)
    );

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     chk_ev;

    // monitor: pops expected items and compares with the ports
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                sb_item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                if (it.kind < 4) rd_addr = it.kind[1:0];
                #0.1;
                act = (it.kind < 4) ? rd_data : {6'b0, irq_ovf, irq_cmp};
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    // driver helpers
    task automatic expect_item(input int kind, input logic [7:0] exp, input string tag);
        sb_item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        -> chk_ev;
        #0.3;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            ext_tick = 1'b1;
            @(negedge clk);
            ext_tick = 1'b0;
        end
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        expect_item(0, 8'h00, "R1 count");
        expect_item(1, 8'h00, "R1 cmp buffer");
        expect_item(2, 8'h00, "R1 ctrl");
        expect_item(3, 8'h00, "R1 flags");
        expect_item(4, 8'h00, "R1 irqs");
        @(negedge clk);
        rst = 1'b0;
        // ctrl write edge still ticks from the clock source; count 0 matches compare 0
        wr(2'd2, 8'h04);
        expect_item(0, 8'h01, "R2 clock source ticks");
        expect_item(3, 8'h01, "R6 match at zero");
        repeat (3) @(negedge clk);
        expect_item(0, 8'h01, "R2 no ext tick holds");
        tk(1);
        expect_item(0, 8'h02, "R2 ext tick advances");
        wr(2'd3, 8'h00);
        expect_item(3, 8'h01, "R9 zero write keeps flag");
        wr(2'd3, 8'h03);
        expect_item(3, 8'h00, "R9 clear");

        // mode 0 wrap
        wr(2'd0, 8'hFE);
        tk(1);
        expect_item(0, 8'hFF, "R3 inc");
        tk(1);
        expect_item(0, 8'h00, "R3 wrap");
        expect_item(3, 8'h02, "R3 overflow flag");
        expect_item(4, 8'h00, "R10 ovf irq masked");
        wr(2'd2, 8'h14);
        expect_item(4, 8'h02, "R10 ovf irq enabled");
        wr(2'd3, 8'h02);
        expect_item(4, 8'h00, "R10 ovf irq after clear");

        // compare match in mode 0, immediate compare update
        wr(2'd0, 8'h0F);
        wr(2'd1, 8'h10);
        tk(1);
        expect_item(3, 8'h00, "R6 no match yet");
        tk(1);
        expect_item(0, 8'h11, "R6 count");
        expect_item(3, 8'h01, "R7 immediate compare in mode 0");
        expect_item(4, 8'h00, "R10 cmp irq masked");
        wr(2'd2, 8'h1C);
        expect_item(4, 8'h01, "R10 cmp irq enabled");
        expect_item(2, 8'h1C, "R11 ctrl readback");
        wr(2'd3, 8'h03);

        // suppressed match after count write
        wr(2'd0, 8'h10);
        tk(1);
        expect_item(0, 8'h11, "R8 count after load");
        expect_item(3, 8'h00, "R8 match suppressed");
        // load wins over simultaneous tick
        ext_tick = 1'b1;
        wr(2'd0, 8'h20);
        ext_tick = 1'b0;
        expect_item(0, 8'h20, "R8 load wins");
        tk(1);
        expect_item(0, 8'h21, "R8 count after win");

        // mode 1 clear on compare
        wr(2'd2, 8'h1D);
        wr(2'd1, 8'h03);
        wr(2'd0, 8'h02);
        tk(1);
        expect_item(0, 8'h03, "R4 up to top");
        tk(1);
        expect_item(0, 8'h00, "R4 clear at compare");
        expect_item(3, 8'h01, "R6 match in mode 1");
        tk(1);
        expect_item(0, 8'h01, "R4 restart");
        wr(2'd3, 8'h03);
        wr(2'd0, 8'hFE);
        tk(2);
        expect_item(0, 8'h00, "R4 wrap above top");
        expect_item(3, 8'h02, "R4 overflow above top");
        wr(2'd3, 8'h03);

        // mode 2 up/down, deferred compare
        wr(2'd2, 8'h1E);
        wr(2'd1, 8'h40);
        expect_item(1, 8'h40, "R11 buffer readback");
        wr(2'd0, 8'h02);
        tk(2);
        expect_item(0, 8'h04, "R5 up count");
        expect_item(3, 8'h01, "R7 old active compare kept");
        wr(2'd3, 8'h03);
        wr(2'd0, 8'hFE);
        tk(1);
        expect_item(0, 8'hFF, "R5 reach top");
        tk(1);
        expect_item(0, 8'hFE, "R5 turn down");
        tk(1);
        expect_item(0, 8'hFD, "R5 counting down");
        wr(2'd0, 8'h41);
        tk(2);
        expect_item(0, 8'h3F, "R5 down past compare");
        expect_item(3, 8'h01, "R7 new compare active after top");
        wr(2'd3, 8'h03);
        wr(2'd0, 8'h02);
        tk(1);
        expect_item(0, 8'h01, "R5 down");
        expect_item(3, 8'h00, "R5 no ovf before bottom");
        tk(1);
        expect_item(0, 8'h00, "R5 bottom");
        expect_item(3, 8'h02, "R5 ovf at bottom");
        expect_item(4, 8'h02, "R10 ovf irq mode 2");
        tk(1);
        expect_item(0, 8'h01, "R5 turn up");
        tk(1);
        expect_item(0, 8'h02, "R5 rising again");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule